// File: doc/BRIEF.md
# Synchronous Dual-Port RAM

A true dual-port synchronous static memory with two independent access ports, A and B, that share one clock. Each port samples its address, write data, read/write control, two active-low byte-lane selects and a two-pin chip select on the rising edge. Either port can read or write any word in any cycle, and both ports can work on the same word at once. Read data leaves each port as a data word plus a per-lane drive flag, which stands in for a tri-state bus. An undriven lane always reads as zero.

Each port has its own run-time output mode. In flow mode the word read at an edge appears right after that edge. In pipelined mode one more output register sits in the path, so the word appears one edge later. The same registers carry the chip-select and lane decisions, so the output state in a cycle follows the controls of the access that produced it. The output enable does not pass through any register: raising it removes drive at once. Depth and lane width are parameters, for example 16K, 32K or 64K words of two 8-bit or two 9-bit lanes. Memory contents are not initialised.

Top module: `dpr_top`

## Requirements
- R1: A port takes part in an access only when its `_sel_n` is 0 and its `_sel` is 1 at the edge. Any other combination writes nothing, and that access drives no lane.
- R2: A selected access with `_wr_n` = 0 at the edge is a write. With `_wr_n` = 1 it is a read of the word at `_addr`.
- R3: With `_pipe` = 0, the data of a read sampled at edge k is on `_rdata` with its lanes flagged in `_rvalid` directly after edge k.
- R4: With `_pipe` = 1, the result of the access sampled at edge k (data, lane flags or silence) is presented directly after edge k+1.
- R5: A write updates only the lanes whose `_lane_n` bit is 0. Bit 0 selects data bits [LANE_W-1:0] and bit 1 selects the upper LANE_W bits. The other lanes keep their stored value.
- R6: A read drives only the lanes whose `_lane_n` bit was 0. A lane that is not driven has its `_rvalid` bit at 0 and its `_rdata` bits at zero.
- R7: While `_oe_n` is 1 no lane of that port is driven. The change takes effect without waiting for a clock edge.
- R8: A write access drives no lane in the cycle that presents its result.
- R9: The two ports work independently and at the same time. A word written on one port is read back on the other port from the next edge on. A read on one port in the same cycle as a write to that word on the other port returns the old contents. If both ports write the same lane of the same word in one cycle, the stored value is undefined.
- R10: While `rst` is 1 at an edge, no write takes effect. After that edge `_rvalid` is 0 on both ports in both modes, and `_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| a_sel_n | input | 1 | Port A chip select, active low half |
| a_sel | input | 1 | Port A chip select, active high half |
| a_wr_n | input | 1 | Port A: 0 write, 1 read |
| a_lane_n | input | 2 | Port A byte-lane selects, active low (bit 0 lower lane) |
| a_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| a_pipe | input | 1 | Port A output mode: 0 flow, 1 pipelined |
| a_addr | input | AW | Port A word address |
| a_wdata | input | 2*LANE_W | Port A write data |
| a_rdata | output | 2*LANE_W | Port A read data, zero on undriven lanes |
| a_rvalid | output | 2 | Port A per-lane drive flags |
| b_sel_n | input | 1 | Port B chip select, active low half |
| b_sel | input | 1 | Port B chip select, active high half |
| b_wr_n | input | 1 | Port B: 0 write, 1 read |
| b_lane_n | input | 2 | Port B byte-lane selects, active low (bit 0 lower lane) |
| b_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| b_pipe | input | 1 | Port B output mode: 0 flow, 1 pipelined |
| b_addr | input | AW | Port B word address |
| b_wdata | input | 2*LANE_W | Port B write data |
| b_rdata | output | 2*LANE_W | Port B read data, zero on undriven lanes |
| b_rvalid | output | 2 | Port B per-lane drive flags |

## Verification
The bench targets the one-edge difference between the two output modes. A design that put the extra register in flow mode, or left it out in pipelined mode, would show data at the wrong edge, or would show silence where a write or a deselected access should still be visible. The bench writes single lanes and reads with partial lane masks. A design that ignored a lane select would corrupt the neighbouring lane or drive it. It also toggles the output enable between edges, which exposes any design that registers it. Finally, it reads a word on one port in the same cycle as the other port writes it. A design that forwarded the new value, or lost the write, would return the wrong word then or one cycle later.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int LANES = 2;
  typedef enum logic {OUT_FLOW = 1'b0, OUT_PIPE = 1'b1} out_mode_e;
endpackage

// File: rtl/dpr_req.sv
// Per-port request decode: write lane strobes now, read lane flags one edge later.
module dpr_req import dpr_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             sel,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] wr_lanes,
  output logic [LANES-1:0] rd_act
);
  logic picked;

  always_comb begin
    picked   = !sel_n && sel && !rst;
    wr_lanes = (picked && !wr_n) ? ~lane_n : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_act <= '0;
    else     rd_act <= (picked && wr_n) ? ~lane_n : '0;
  end
endmodule

// File: rtl/dpr_mem.sv
// Storage array with per-lane writes and a registered read per port (read-first).
module dpr_mem import dpr_pkg::*; #(
  parameter  int DEPTH  = 1024,
  parameter  int LANE_W = 8,
  parameter  int NPORT  = 2,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic [AW-1:0]                 addr     [NPORT],
  input  logic [LANES-1:0][LANE_W-1:0]  wdata    [NPORT],
  input  logic [LANES-1:0]              wr_lanes [NPORT],
  output logic [LANES-1:0][LANE_W-1:0]  rdata    [NPORT]
);
  logic [LANES-1:0][LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    // Highest port first so port 0 lands last on a same-lane collision.
    for (int p = NPORT-1; p >= 0; p--) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lanes[p][l]) cells[addr[p]][l] <= wdata[p][l];
      end
    end
    for (int p = 0; p < NPORT; p++) begin
      rdata[p] <= cells[addr[p]];
    end
  end
endmodule

// File: rtl/dpr_drive.sv
// Output path of one port: optional extra register, then lane and enable gating.
module dpr_drive import dpr_pkg::*; #(
  parameter int LANE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pipe,
  input  logic                          oe_n,
  input  logic [LANES-1:0]              rd_act,
  input  logic [LANES-1:0][LANE_W-1:0]  mem_q,
  output logic [LANES*LANE_W-1:0]       rdata,
  output logic [LANES-1:0]              rvalid
);
  logic [LANES-1:0]             act_d;
  logic [LANES-1:0][LANE_W-1:0] dat_d;
  logic [LANES-1:0]             act_sel;
  logic [LANES-1:0][LANE_W-1:0] dat_sel;

  always_ff @(posedge clk) begin
    if (rst) act_d <= '0;
    else     act_d <= rd_act;
    dat_d <= mem_q;
  end

  always_comb begin
    if (out_mode_e'(pipe) == OUT_PIPE) begin
      act_sel = act_d;
      dat_sel = dat_d;
    end else begin
      act_sel = rd_act;
      dat_sel = mem_q;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rvalid[l] = act_sel[l] & ~oe_n;
    assign rdata[l*LANE_W +: LANE_W] = rvalid[l] ? dat_sel[l] : '0;
  end
endmodule

// File: rtl/dpr_top.sv
module dpr_top import dpr_pkg::*; #(
  parameter  int DEPTH  = 1024,
  parameter  int LANE_W = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int W      = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_sel_n,
  input  logic             a_sel,
  input  logic             a_wr_n,
  input  logic [LANES-1:0] a_lane_n,
  input  logic             a_oe_n,
  input  logic             a_pipe,
  input  logic [AW-1:0]    a_addr,
  input  logic [W-1:0]     a_wdata,
  output logic [W-1:0]     a_rdata,
  output logic [LANES-1:0] a_rvalid,
  input  logic             b_sel_n,
  input  logic             b_sel,
  input  logic             b_wr_n,
  input  logic [LANES-1:0] b_lane_n,
  input  logic             b_oe_n,
  input  logic             b_pipe,
  input  logic [AW-1:0]    b_addr,
  input  logic [W-1:0]     b_wdata,
  output logic [W-1:0]     b_rdata,
  output logic [LANES-1:0] b_rvalid
);
  localparam int NP = 2;

  logic                         p_sel_n [NP];
  logic                         p_sel   [NP];
  logic                         p_wr_n  [NP];
  logic [LANES-1:0]             p_lane_n[NP];
  logic                         p_oe_n  [NP];
  logic                         p_pipe  [NP];
  logic [AW-1:0]                p_addr  [NP];
  logic [LANES-1:0][LANE_W-1:0] p_wdata [NP];
  logic [LANES-1:0]             p_wlane [NP];
  logic [LANES-1:0]             p_ract  [NP];
  logic [LANES-1:0][LANE_W-1:0] p_memq  [NP];
  logic [W-1:0]                 p_rdata [NP];
  logic [LANES-1:0]             p_rvalid[NP];

  assign p_sel_n[0] = a_sel_n;   assign p_sel_n[1] = b_sel_n;
  assign p_sel[0]   = a_sel;     assign p_sel[1]   = b_sel;
  assign p_wr_n[0]  = a_wr_n;    assign p_wr_n[1]  = b_wr_n;
  assign p_lane_n[0]= a_lane_n;  assign p_lane_n[1]= b_lane_n;
  assign p_oe_n[0]  = a_oe_n;    assign p_oe_n[1]  = b_oe_n;
  assign p_pipe[0]  = a_pipe;    assign p_pipe[1]  = b_pipe;
  assign p_addr[0]  = a_addr;    assign p_addr[1]  = b_addr;
  assign p_wdata[0] = a_wdata;   assign p_wdata[1] = b_wdata;
  assign a_rdata    = p_rdata[0];  assign b_rdata  = p_rdata[1];
  assign a_rvalid   = p_rvalid[0]; assign b_rvalid = p_rvalid[1];

  for (genvar p = 0; p < NP; p++) begin : g_port
    dpr_req u_req (
      .clk      (clk),
      .rst      (rst),
      .sel_n    (p_sel_n[p]),
      .sel      (p_sel[p]),
      .wr_n     (p_wr_n[p]),
      .lane_n   (p_lane_n[p]),
      .wr_lanes (p_wlane[p]),
      .rd_act   (p_ract[p])
    );

    dpr_drive #(.LANE_W(LANE_W)) u_drive (
      .clk    (clk),
      .rst    (rst),
      .pipe   (p_pipe[p]),
      .oe_n   (p_oe_n[p]),
      .rd_act (p_ract[p]),
      .mem_q  (p_memq[p]),
      .rdata  (p_rdata[p]),
      .rvalid (p_rvalid[p])
    );
  end

  dpr_mem #(.DEPTH(DEPTH), .LANE_W(LANE_W), .NPORT(NP)) u_mem (
    .clk      (clk),
    .addr     (p_addr),
    .wdata    (p_wdata),
    .wr_lanes (p_wlane),
    .rdata    (p_memq)
  );
endmodule

// File: rtl/dpr_chk.sv
module dpr_chk #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                a_sel_n,
  input logic                a_sel,
  input logic                a_wr_n,
  input logic                a_oe_n,
  input logic                a_pipe,
  input logic [2*LANE_W-1:0] a_rdata,
  input logic [1:0]          a_rvalid,
  input logic                b_sel_n,
  input logic                b_sel,
  input logic                b_wr_n,
  input logic                b_oe_n,
  input logic                b_pipe,
  input logic [2*LANE_W-1:0] b_rdata,
  input logic [1:0]          b_rvalid
);
  assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (a_rvalid == 2'b00 && b_rvalid == 2'b00));

  assert_oe_blocks_a_R7: assert property (@(posedge clk) disable iff (rst)
    a_oe_n |-> a_rvalid == 2'b00);

  assert_oe_blocks_b_R7: assert property (@(posedge clk) disable iff (rst)
    b_oe_n |-> b_rvalid == 2'b00);

  assert_idle_lane_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (!a_rvalid[0] |-> a_rdata[LANE_W-1:0] == '0) and
    (!a_rvalid[1] |-> a_rdata[2*LANE_W-1:LANE_W] == '0) and
    (!b_rvalid[0] |-> b_rdata[LANE_W-1:0] == '0) and
    (!b_rvalid[1] |-> b_rdata[2*LANE_W-1:LANE_W] == '0));

  assert_write_silent_flow_R8: assert property (@(posedge clk) disable iff (rst)
    (!a_pipe && !a_sel_n && a_sel && !a_wr_n) |=> (!$stable(a_pipe) || a_rvalid == 2'b00));

  assert_deselect_silent_flow_R1: assert property (@(posedge clk) disable iff (rst)
    (!b_pipe && (b_sel_n || !b_sel)) |=> (!$stable(b_pipe) || b_rvalid == 2'b00));

  assert_write_silent_pipe_R4: assert property (@(posedge clk) disable iff (rst)
    (a_pipe && !a_sel_n && a_sel && !a_wr_n) ##1 a_pipe |=> (!a_pipe || a_rvalid == 2'b00));
endmodule

bind dpr_top dpr_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst),
  .a_sel_n(a_sel_n), .a_sel(a_sel), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_pipe(a_pipe),
  .a_rdata(a_rdata), .a_rvalid(a_rvalid),
  .b_sel_n(b_sel_n), .b_sel(b_sel), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_pipe(b_pipe),
  .b_rdata(b_rdata), .b_rvalid(b_rvalid)
);

// File: tb/sim_dpr_top.sv
module sim_dpr_top;
  localparam int DEPTH = 1024;
  localparam int LW    = 8;
  localparam int AW    = 10;
  localparam int W     = 2 * LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          sel_n [2];
  logic          sel   [2];
  logic          wr_n  [2];
  logic [1:0]    lane_n[2];
  logic          oe_n  [2];
  logic          pipe  [2];
  logic [AW-1:0] addr  [2];
  logic [W-1:0]  wdata [2];
  logic [W-1:0]  a_rdata, b_rdata;
  logic [1:0]    a_rvalid, b_rvalid;

  dpr_top #(.DEPTH(DEPTH), .LANE_W(LW)) u0 (
    .clk(clk), .rst(rst),
    .a_sel_n(sel_n[0]), .a_sel(sel[0]), .a_wr_n(wr_n[0]), .a_lane_n(lane_n[0]),
    .a_oe_n(oe_n[0]), .a_pipe(pipe[0]), .a_addr(addr[0]), .a_wdata(wdata[0]),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_sel_n(sel_n[1]), .b_sel(sel[1]), .b_wr_n(wr_n[1]), .b_lane_n(lane_n[1]),
    .b_oe_n(oe_n[1]), .b_pipe(pipe[1]), .b_addr(addr[1]), .b_wdata(wdata[1]),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] mdl   [DEPTH];
  logic [1:0]   known [DEPTH];
  logic [1:0]   cur_act[2], prv_act[2], cur_kn[2], prv_kn[2];
  logic [W-1:0] cur_dat[2], prv_dat[2];

  task automatic chk(input string tag, input string what, input int p,
                     input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s port %0d %s: got %h expected %h", tag, p, what, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    for (int p = 0; p < 2; p++) begin
      logic [1:0]   ea, ek, ev, gv;
      logic [W-1:0] ed, gd, ex, mask;
      ea = pipe[p] ? prv_act[p] : cur_act[p];
      ek = pipe[p] ? prv_kn[p]  : cur_kn[p];
      ed = pipe[p] ? prv_dat[p] : cur_dat[p];
      ev = oe_n[p] ? 2'b00 : ea;
      gv = (p == 0) ? a_rvalid : b_rvalid;
      gd = (p == 0) ? a_rdata  : b_rdata;
      chk(tag, "rvalid", p, {14'd0, gv}, {14'd0, ev});
      ex = '0; mask = '0;
      for (int l = 0; l < 2; l++) begin
        if (!ev[l]) mask[l*LW +: LW] = '1;
        else if (ek[l]) begin
          mask[l*LW +: LW] = '1;
          ex[l*LW +: LW]   = ed[l*LW +: LW];
        end
      end
      chk(tag, "rdata", p, gd & mask, ex & mask);
    end
  endtask

  task automatic step(input string tag);
    logic [1:0]   nact[2], nkn[2], wl[2];
    logic [W-1:0] ndat[2];
    for (int p = 0; p < 2; p++) begin
      logic ok;
      ok      = !sel_n[p] && sel[p] && !rst;
      nact[p] = (ok && wr_n[p])  ? ~lane_n[p] : 2'b00;
      wl[p]   = (ok && !wr_n[p]) ? ~lane_n[p] : 2'b00;
      ndat[p] = mdl[addr[p]];
      nkn[p]  = known[addr[p]];
    end
    for (int p = 1; p >= 0; p--) begin
      for (int l = 0; l < 2; l++) begin
        if (wl[p][l]) begin
          mdl[addr[p]][l*LW +: LW] = wdata[p][l*LW +: LW];
          known[addr[p]][l] = 1'b1;
        end
      end
    end
    if (addr[0] == addr[1]) known[addr[0]] = known[addr[0]] & ~(wl[0] & wl[1]);
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      prv_act[p] = rst ? 2'b00 : cur_act[p];
      prv_kn[p]  = cur_kn[p];
      prv_dat[p] = cur_dat[p];
      cur_act[p] = nact[p];
      cur_kn[p]  = nkn[p];
      cur_dat[p] = ndat[p];
    end
    #2;
    compare(tag);
  endtask

  task automatic idle(input int p);
    sel_n[p] = 1'b1; sel[p] = 1'b1; wr_n[p] = 1'b1; lane_n[p] = 2'b00;
    oe_n[p] = 1'b0; addr[p] = '0; wdata[p] = '0;
  endtask

  task automatic acc(input int p, input logic wr, input logic [AW-1:0] ad,
                     input logic [W-1:0] d, input logic [1:0] ln);
    sel_n[p] = 1'b0; sel[p] = 1'b1; wr_n[p] = !wr; lane_n[p] = ln;
    addr[p] = ad; wdata[p] = d;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) begin mdl[i] = '0; known[i] = 2'b00; end
    for (int p = 0; p < 2; p++) begin
      cur_act[p] = '0; prv_act[p] = '0; cur_kn[p] = '0; prv_kn[p] = '0;
      cur_dat[p] = '0; prv_dat[p] = '0; pipe[p] = 1'b0; idle(p);
    end
    // R10: reset state, a write attempted under reset must not land
    rst = 1'b1;
    acc(0, 1'b1, 10'd3, 16'hdead, 2'b00);
    repeat (3) step("R10");
    rst = 1'b0; idle(0);
    step("R10");

    // R8 then R3 (R2): flow write, then read back
    acc(0, 1'b1, 10'd5, 16'h1234, 2'b00); step("R8");
    acc(0, 1'b0, 10'd5, 16'h0,    2'b00); step("R3");
    chk("R3", "direct", 0, a_rdata, 16'h1234);

    // R4: pipelined write, read, then idle shows the read one edge late
    pipe[0] = 1'b1;
    acc(0, 1'b1, 10'd6, 16'habcd, 2'b00); step("R4");
    acc(0, 1'b0, 10'd6, 16'h0,    2'b00); step("R4");
    chk("R4", "late_write", 0, {14'd0, a_rvalid}, 16'd0);
    idle(0); step("R4");
    chk("R4", "direct", 0, a_rdata, 16'habcd);
    step("R1");
    chk("R1", "pipe_deselect", 0, {14'd0, a_rvalid}, 16'd0);
    pipe[0] = 1'b0;

    // R5: lower-lane-only write
    acc(0, 1'b1, 10'd5, 16'h5577, 2'b10); step("R5");
    acc(0, 1'b0, 10'd5, 16'h0,    2'b00); step("R5");
    chk("R5", "direct", 0, a_rdata, 16'h1277);

    // R6: upper lane only driven
    acc(0, 1'b0, 10'd5, 16'h0, 2'b01); step("R6");
    chk("R6", "direct", 0, a_rdata, 16'h1200);

    // R1: half-selected write ignored, half-selected read silent
    acc(0, 1'b1, 10'd5, 16'hffff, 2'b00); sel[0] = 1'b0; step("R1");
    acc(0, 1'b0, 10'd5, 16'h0, 2'b00); sel_n[0] = 1'b1; step("R1");
    acc(0, 1'b0, 10'd5, 16'h0, 2'b00); step("R1");
    chk("R1", "direct", 0, a_rdata, 16'h1277);

    // R9: cross-port write/read, same-cycle read sees old data
    acc(0, 1'b1, 10'd5, 16'h0f0f, 2'b00); acc(1, 1'b0, 10'd5, 16'h0, 2'b00); step("R9");
    chk("R9", "old_data", 1, b_rdata, 16'h1277);
    idle(0); step("R9");
    chk("R9", "new_data", 1, b_rdata, 16'h0f0f);
    acc(1, 1'b1, 10'd8, 16'h4242, 2'b00); idle(0); step("R9");
    acc(0, 1'b0, 10'd8, 16'h0, 2'b00); idle(1); step("R9");
    chk("R9", "b_to_a", 0, a_rdata, 16'h4242);

    // R7: output enable acts between edges
    oe_n[0] = 1'b1; #1; compare("R7");
    chk("R7", "async_off", 0, {14'd0, a_rvalid}, 16'd0);
    oe_n[0] = 1'b0; #1; compare("R7");
    chk("R7", "async_on", 0, {14'd0, a_rvalid}, 16'd3);

    // Random mix over a small address window (R2, R9)
    for (int i = 0; i < 600; i++) begin
      for (int p = 0; p < 2; p++) begin
        pipe[p]   = ((i / 64) % 2) != p;
        sel_n[p]  = ($urandom % 8) == 0;
        sel[p]    = ($urandom % 8) != 0;
        wr_n[p]   = ($urandom % 2) != 0;
        lane_n[p] = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
        oe_n[p]   = ($urandom % 6) == 0;
        addr[p]   = 10'($urandom % 16);
        wdata[p]  = 16'($urandom);
      end
      rst = (i == 300);
      step("R2");
    end
    rst = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule